// File: doc/BRIEF.md
# Masked Time and Date Alarm Comparator

This block holds two programmed alarm words, one for time of day and one for the calendar. On every one-second strobe it compares them against the current time and date words from a separate counter. Each alarm field carries its own enable bit, and only enabled fields take part in the comparison. When every enabled field agrees with the current value, the block raises a one-cycle alarm pulse.

Each alarm word is checked for legal BCD content, using the 12/24-hour mode for the hour field. The result appears on a non-valid flag per word. While either flag is set, no alarm is raised. The counter that produces the current time and date lies outside this block.

Top module: `tdalm_top`

## Requirements
- R1: Field positions, shared by the alarm words and the current words. In the time word, seconds sit in bits 6:0 (enable bit 7) and minutes in bits 14:8 (enable bit 15). Hours sit in bits 21:16 with the PM indicator in bit 22 and the hour enable in bit 23. In the calendar word, month sits in bits 20:16 (enable bit 23) and day of month in bits 29:24 (enable bit 31). All other bits are ignored.
- R2: `alarm_pulse` is high in the cycle after a cycle in which `sec_tick` is high and every enabled field equals the current field. It is never high after a cycle without `sec_tick`, and it lasts one cycle for a one-cycle strobe.
- R3: With no enable bit set in either alarm word, `alarm_pulse` stays low.
- R4: With `hour12_mode`=1 (12-hour), an hour match needs both equal hour digits and equal PM bits. With `hour12_mode`=0 (24-hour), the PM bit is ignored on both sides.
- R5: `talm_bad` is set when an enabled time field is not legal BCD. A field is illegal when any digit is above 9 or the value is out of range. The ranges are: seconds and minutes 00 to 59, hours 00 to 23 in 24-hour mode, and hours 01 to 12 in 12-hour mode.
- R6: `calm_bad` is set when an enabled calendar field is not legal BCD. The ranges are month 01 to 12 and day of month 01 to 31.
- R7: A field whose enable bit is clear is neither validated nor compared, whatever its contents.
- R8: While `talm_bad` or `calm_bad` is high, no alarm pulse is produced.
- R9: A write to an alarm word is reflected in its non-valid flag in the following cycle. A change of `hour12_mode` is reflected in `talm_bad` one clock edge later. Without a write or a mode change, the flags hold.
- R10: After reset both alarm words are zero (nothing enabled), both flags are low and `alarm_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second strobe, one cycle wide |
| hour12_mode | input | 1 | 1 = 12-hour mode, 0 = 24-hour mode |
| cur_time | input | 32 | Current time word (R1 layout) |
| cur_date | input | 32 | Current calendar word (R1 layout) |
| talm_wr | input | 1 | Write strobe for the time alarm word |
| talm_wdata | input | 32 | Time alarm write data |
| calm_wr | input | 1 | Write strobe for the calendar alarm word |
| calm_wdata | input | 32 | Calendar alarm write data |
| alarm_pulse | output | 1 | One-cycle alarm indication |
| talm_bad | output | 1 | Time alarm word holds a non-valid enabled field |
| calm_bad | output | 1 | Calendar alarm word holds a non-valid enabled field |

## Verification
Every 7-bit seconds and minutes code is swept, along with every 6-bit hour code with both PM values in both hour modes, every month code and every day code. This separates the digit-above-9 check from the numeric range check, and the 12-hour range from the 24-hour range. Matching is then tried in several patterns: a single enabled field against a full sweep of the current value, two time fields together, and month with date. Each pattern shows whether disabled fields are really excluded and whether a near miss in one field blocks the pulse. Hour sweeps with the PM bit flipped in each mode separate the two hour comparisons. Illegal entries placed next to otherwise matching times show the suppression, and a mode change on a stored 00 hour shows the re-evaluation timing.

// File: rtl/tdalm_pkg.sv
package tdalm_pkg;
  localparam int WORD_W     = 32;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 5;

  localparam int IDX_SEC   = 0;
  localparam int IDX_MIN   = 1;
  localparam int IDX_HOUR  = 2;
  localparam int IDX_MONTH = 3;
  localparam int IDX_DATE  = 4;

  // field placement inside the time / calendar words
  localparam int FLD_LSB [NUM_FIELDS] = '{0, 8, 16, 16, 24};
  localparam int FLD_W   [NUM_FIELDS] = '{7, 7, 6, 5, 6};
  localparam int FLD_EN  [NUM_FIELDS] = '{7, 15, 23, 23, 31};
  localparam bit FLD_CAL [NUM_FIELDS] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int PM_BIT = 22;

  typedef enum logic {ENTRY_TIME = 1'b0, ENTRY_CAL = 1'b1} entry_kind_e;

  // extract one field, zero-extended to FIELD_W
  function automatic logic [FIELD_W-1:0] fld(input logic [WORD_W-1:0] w, input int idx);
    logic [WORD_W-1:0] s;
    s = (w >> FLD_LSB[idx]) & ((WORD_W'(1) << FLD_W[idx]) - WORD_W'(1));
    return FIELD_W'(s);
  endfunction

  // both digits decimal and value inside [lo, hi] (BCD order equals numeric order)
  function automatic logic bcd_in_range(input logic [FIELD_W-1:0] v,
                                        input logic [FIELD_W-1:0] lo,
                                        input logic [FIELD_W-1:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/tdalm_entry_reg.sv
module tdalm_entry_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = wr ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr) begin
      q <= wdata;
    end
  end
endmodule

// File: rtl/tdalm_validate.sv
module tdalm_validate
  import tdalm_pkg::*;
#(
  parameter entry_kind_e KIND = ENTRY_TIME
) (
  input  logic [WORD_W-1:0] word,
  input  logic              hour12,
  output logic              bad
);
  if (KIND == ENTRY_TIME) begin : g_time
    logic sec_ok, min_ok, hr_ok;
    logic [FIELD_W-1:0] hr;
    always_comb begin
      hr     = fld(word, IDX_HOUR);
      sec_ok = bcd_in_range(fld(word, IDX_SEC), 8'h00, 8'h59);
      min_ok = bcd_in_range(fld(word, IDX_MIN), 8'h00, 8'h59);
      hr_ok  = hour12 ? bcd_in_range(hr, 8'h01, 8'h12)
                      : bcd_in_range(hr, 8'h00, 8'h23);
      bad    = (word[FLD_EN[IDX_SEC]]  && !sec_ok) ||
               (word[FLD_EN[IDX_MIN]]  && !min_ok) ||
               (word[FLD_EN[IDX_HOUR]] && !hr_ok);
    end
  end else begin : g_cal
    logic mon_ok, day_ok;
    logic unused_mode;
    assign unused_mode = hour12;
    always_comb begin
      mon_ok = bcd_in_range(fld(word, IDX_MONTH), 8'h01, 8'h12);
      day_ok = bcd_in_range(fld(word, IDX_DATE),  8'h01, 8'h31);
      bad    = (word[FLD_EN[IDX_MONTH]] && !mon_ok) ||
               (word[FLD_EN[IDX_DATE]]  && !day_ok);
    end
  end
endmodule

// File: rtl/tdalm_matcher.sv
module tdalm_matcher
  import tdalm_pkg::*;
(
  input  logic [WORD_W-1:0] t_alm,
  input  logic [WORD_W-1:0] c_alm,
  input  logic [WORD_W-1:0] t_cur,
  input  logic [WORD_W-1:0] c_cur,
  input  logic              hour12,
  output logic              any_en,
  output logic              all_eq
);
  logic [NUM_FIELDS-1:0] en_v;
  logic [NUM_FIELDS-1:0] eq_v;
  logic                  pm_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic [WORD_W-1:0] a_w;
    logic [WORD_W-1:0] c_w;
    assign a_w     = FLD_CAL[i] ? c_alm : t_alm;
    assign c_w     = FLD_CAL[i] ? c_cur : t_cur;
    assign en_v[i] = a_w[FLD_EN[i]];
    assign eq_v[i] = (fld(a_w, i) == fld(c_w, i));
  end

  always_comb begin
    pm_ok  = !hour12 || (t_alm[PM_BIT] == t_cur[PM_BIT]);
    any_en = |en_v;
    all_eq = (&(~en_v | eq_v)) && (!en_v[IDX_HOUR] || pm_ok);
  end
endmodule

// File: rtl/tdalm_top.sv
module tdalm_top
  import tdalm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              hour12_mode,
  input  logic [WORD_W-1:0] cur_time,
  input  logic [WORD_W-1:0] cur_date,
  input  logic              talm_wr,
  input  logic [WORD_W-1:0] talm_wdata,
  input  logic              calm_wr,
  input  logic [WORD_W-1:0] calm_wdata,
  output logic              alarm_pulse,
  output logic              talm_bad,
  output logic              calm_bad
);
  logic [WORD_W-1:0] talm_q, talm_nxt;
  logic [WORD_W-1:0] calm_q, calm_nxt;
  logic              tbad_d, cbad_d, pulse_d;
  logic              match_any_en, match_all_eq;

  tdalm_entry_reg #(.W(WORD_W)) u_treg (
    .clk(clk), .rst_n(rst_n), .wr(talm_wr), .wdata(talm_wdata),
    .q(talm_q), .nxt(talm_nxt)
  );

  tdalm_entry_reg #(.W(WORD_W)) u_creg (
    .clk(clk), .rst_n(rst_n), .wr(calm_wr), .wdata(calm_wdata),
    .q(calm_q), .nxt(calm_nxt)
  );

  tdalm_validate #(.KIND(ENTRY_TIME)) u_tval (
    .word(talm_nxt), .hour12(hour12_mode), .bad(tbad_d)
  );

  tdalm_validate #(.KIND(ENTRY_CAL)) u_cval (
    .word(calm_nxt), .hour12(hour12_mode), .bad(cbad_d)
  );

  tdalm_matcher u_match (
    .t_alm(talm_q), .c_alm(calm_q), .t_cur(cur_time), .c_cur(cur_date),
    .hour12(hour12_mode), .any_en(match_any_en), .all_eq(match_all_eq)
  );

  always_comb begin
    pulse_d = sec_tick && match_any_en && match_all_eq && !talm_bad && !calm_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      talm_bad    <= 1'b0;
      calm_bad    <= 1'b0;
      alarm_pulse <= 1'b0;
    end else begin
      talm_bad    <= tbad_d;
      calm_bad    <= cbad_d;
      alarm_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/tdalm_checker.sv
module tdalm_checker (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic hour12_mode,
  input logic talm_wr,
  input logic calm_wr,
  input logic alarm_pulse,
  input logic talm_bad,
  input logic calm_bad,
  input logic any_en
);
  assert_pulse_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(sec_tick));

  assert_pulse_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(any_en));

  assert_no_pulse_when_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> (!$past(talm_bad) && !$past(calm_bad)));

  assert_tflag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!talm_wr && (hour12_mode == $past(hour12_mode))) |=> $stable(talm_bad));

  assert_cflag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !calm_wr |=> $stable(calm_bad));
endmodule

bind tdalm_top tdalm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hour12_mode(hour12_mode),
  .talm_wr(talm_wr), .calm_wr(calm_wr), .alarm_pulse(alarm_pulse),
  .talm_bad(talm_bad), .calm_bad(calm_bad), .any_en(match_any_en)
);

// File: tb/tdalm_top_tb_top.sv
module tdalm_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, sec_tick, hour12_mode, talm_wr, calm_wr;
  logic [31:0] cur_time, cur_date, talm_wdata, calm_wdata;
  logic        alarm_pulse, talm_bad, calm_bad;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] ta = '0, ca = '0;
  bit h12 = 0;

  tdalm_top dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hour12_mode(hour12_mode),
    .cur_time(cur_time), .cur_date(cur_date), .talm_wr(talm_wr),
    .talm_wdata(talm_wdata), .calm_wr(calm_wr), .calm_wdata(calm_wdata),
    .alarm_pulse(alarm_pulse), .talm_bad(talm_bad), .calm_bad(calm_bad)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int i2b(input int d);
    return ((d / 10) << 4) | (d % 10);
  endfunction

  function automatic bit in_rng(input int v, input int lo, input int hi);
    int dec;
    if ((v & 15) > 9 || (v >> 4) > 9) return 0;
    dec = (v >> 4) * 10 + (v & 15);
    return (dec >= lo) && (dec <= hi);
  endfunction

  function automatic bit m_tbad(input logic [31:0] w, input bit m12);
    bit b = 0;
    if (w[7]  && !in_rng(int'(w[6:0]), 0, 59)) b = 1;
    if (w[15] && !in_rng(int'(w[14:8]), 0, 59)) b = 1;
    if (w[23] && !(m12 ? in_rng(int'(w[21:16]), 1, 12) : in_rng(int'(w[21:16]), 0, 23))) b = 1;
    return b;
  endfunction

  function automatic bit m_cbad(input logic [31:0] w);
    bit b = 0;
    if (w[23] && !in_rng(int'(w[20:16]), 1, 12)) b = 1;
    if (w[31] && !in_rng(int'(w[29:24]), 1, 31)) b = 1;
    return b;
  endfunction

  function automatic bit m_alarm(input logic [31:0] t, input logic [31:0] c, input bit m12,
                                 input logic [31:0] ct, input logic [31:0] cd);
    bit hit = 1;
    if (m_tbad(t, m12) || m_cbad(c)) return 0;
    if (!(t[7] || t[15] || t[23] || c[23] || c[31])) return 0;
    if (t[7]  && t[6:0]   != ct[6:0])   hit = 0;
    if (t[15] && t[14:8]  != ct[14:8])  hit = 0;
    if (t[23] && (t[21:16] != ct[21:16] || (m12 && t[22] != ct[22]))) hit = 0;
    if (c[23] && c[20:16] != cd[20:16]) hit = 0;
    if (c[31] && c[29:24] != cd[29:24]) hit = 0;
    return hit;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_t(input logic [31:0] w);
    @(negedge clk); talm_wr = 1'b1; talm_wdata = w;
    @(negedge clk); talm_wr = 1'b0; ta = w;
  endtask

  task automatic wr_c(input logic [31:0] w);
    @(negedge clk); calm_wr = 1'b1; calm_wdata = w;
    @(negedge clk); calm_wr = 1'b0; ca = w;
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk); hour12_mode = m; h12 = m;
    @(negedge clk);
  endtask

  task automatic tick(input string req, input logic [31:0] ct, input logic [31:0] cd);
    bit e;
    @(negedge clk); cur_time = ct; cur_date = cd; sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    e = m_alarm(ta, ca, h12, ct, cd);
    chk(req, int'(alarm_pulse), int'(e));
    if (e) begin
      @(negedge clk);
      chk("R2 single-cycle pulse", int'(alarm_pulse), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; hour12_mode = 1'b0; talm_wr = 1'b0; calm_wr = 1'b0;
    cur_time = '0; cur_date = '0; talm_wdata = '0; calm_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 pulse after reset", int'(alarm_pulse), 0);
    chk("R10 talm_bad after reset", int'(talm_bad), 0);
    chk("R10 calm_bad after reset", int'(calm_bad), 0);
    tick("R10 words cleared, no alarm", 32'h0, 32'h0);

    // R5 seconds and minutes sweeps (R1 positions)
    for (int v = 0; v < 128; v++) begin
      wr_t(32'h80 | 32'(v));
      chk("R5 seconds validity", int'(talm_bad), int'(m_tbad(ta, h12)));
    end
    for (int v = 0; v < 128; v++) begin
      wr_t(32'h8000 | (32'(v) << 8));
      chk("R5 minutes validity", int'(talm_bad), int'(m_tbad(ta, h12)));
    end
    // R5 hour sweep in both modes, both PM values
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int v = 0; v < 64; v++) begin
        for (int p = 0; p < 2; p++) begin
          wr_t((32'h1 << 23) | (32'(p) << 22) | (32'(v) << 16));
          chk("R5 hour validity", int'(talm_bad), int'(m_tbad(ta, h12)));
        end
      end
    end
    set_mode(1'b0);

    // R7 garbage in disabled fields
    wr_t(32'h007F_7F7F);
    chk("R7 disabled time fields not validated", int'(talm_bad), 0);
    wr_c(32'h7F1F_0000);
    chk("R7 disabled calendar fields not validated", int'(calm_bad), 0);
    tick("R7/R3 no enabled field, no alarm", 32'h007F_7F7F, 32'h7F1F_0000);

    // R6 month and day sweeps
    for (int v = 0; v < 32; v++) begin
      wr_c((32'h1 << 23) | (32'(v) << 16));
      chk("R6 month validity", int'(calm_bad), int'(m_cbad(ca)));
    end
    for (int v = 0; v < 64; v++) begin
      wr_c((32'h1 << 31) | (32'(v) << 24));
      chk("R6 day validity", int'(calm_bad), int'(m_cbad(ca)));
    end
    wr_c(32'h0);

    // R9 mode change re-evaluates a stored hour 00
    wr_t(32'h0080_0000);
    chk("R9 hour 00 legal in 24h", int'(talm_bad), 0);
    set_mode(1'b1);
    chk("R9 hour 00 illegal after switch to 12h", int'(talm_bad), 1);
    set_mode(1'b0);
    chk("R9 hour 00 legal again after switch back", int'(talm_bad), 0);

    // R2 seconds-only alarm swept against every second
    wr_t(32'h80 | 32'h30);
    for (int s = 0; s < 60; s++) tick("R2 seconds match sweep", 32'(i2b(s)) | 32'h0012_4400, 32'h0);
    // R2 no strobe, matching time held
    @(negedge clk); cur_time = 32'h30; sec_tick = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R2 no pulse without strobe", int'(alarm_pulse), 0);
    end
    // R2 seconds and minutes together
    wr_t(32'h8000 | 32'h80 | (32'h42 << 8) | 32'h15);
    for (int mi = 0; mi < 60; mi++) begin
      tick("R2 minute+second match", (32'(i2b(mi)) << 8) | 32'h15, 32'h0);
      tick("R2 minute match, second off by one", (32'(i2b(mi)) << 8) | 32'h16, 32'h0);
    end

    // R4 12-hour mode: PM must agree
    set_mode(1'b1);
    wr_t((32'h1 << 23) | (32'h1 << 22) | (32'h07 << 16));
    for (int h = 1; h <= 12; h++)
      for (int p = 0; p < 2; p++)
        tick("R4 12h hour with PM", (32'(p) << 22) | (32'(i2b(h)) << 16), 32'h0);
    // R4 24-hour mode: PM ignored
    set_mode(1'b0);
    wr_t((32'h1 << 23) | (32'h1 << 22) | (32'h19 << 16));
    chk("R4 PM bit ignored for 24h validity", int'(talm_bad), 0);
    for (int h = 0; h < 24; h++)
      for (int p = 0; p < 2; p++)
        tick("R4 24h hour, PM ignored", (32'(p) << 22) | (32'(i2b(h)) << 16), 32'h0);

    // R2 calendar match (month + day), time alarm disabled
    wr_t(32'h0);
    wr_c((32'h1 << 31) | (32'h1 << 23) | (32'h29 << 24) | (32'h02 << 16));
    for (int mo = 1; mo <= 12; mo++) tick("R2 month sweep", 32'h0, (32'h29 << 24) | (32'(i2b(mo)) << 16));
    for (int d = 1; d <= 31; d++) tick("R2 day sweep", 32'h0, (32'(i2b(d)) << 24) | (32'h02 << 16));

    // R8 suppression by illegal entries
    wr_c(32'h0);
    wr_t(32'h80 | 32'h5A);
    chk("R8 illegal seconds flagged", int'(talm_bad), 1);
    tick("R8 illegal time alarm suppresses match", 32'h5A, 32'h0);
    wr_t(32'h80 | 32'h10);
    wr_c((32'h1 << 23) | (32'h13 << 16));
    chk("R8 illegal month flagged", int'(calm_bad), 1);
    tick("R8 illegal calendar alarm suppresses time match", 32'h10, 32'h0013_0000);
    wr_c(32'h0);
    tick("R8 match restored after legal write", 32'h10, 32'h0);

    // R3 nothing enabled
    wr_t(32'h0);
    for (int s = 0; s < 5; s++) tick("R3 no enable, no alarm", 32'(i2b(s)), 32'h0101_0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule